// File: doc/BRIEF.md
# Coherence Event Decoder with Acknowledgement Counter

This block sits in front of a private mid-level cache line controller. Each cycle it looks at the heads of three inbound queues: responses from the shared level, requests forwarded by the shared level, and requests from the private cache above. It picks one head by fixed priority and turns it into exactly one coherence event for the line controller. It also reports the address the event applies to, a one-hot dequeue strobe and an error flag. The queues themselves and the network are outside the block.

The selected head's address is driven out on `look_addr_o`. The line controller answers in the same cycle with that line's state, a valid flag, a free-way flag and the victim line's address and state. These inputs steer the decode. A request is redirected into an invalidation of the upper cache when the line is also held above. A request that misses with no free way produces an eviction event for the victim instead.

The block also holds a signed pending-acknowledgement count for the open transaction. The count is cleared when a transaction opens. Every consumed data or ack response subtracts the ack count that response carries. The difference between the count and the incoming ack count decides whether data or an ack is the final one.

Top module: `coh_event_decoder`

## Requirements
- R1: Priority is fixed: response queue, then forwarded queue, then upper queue. `look_addr_o` is the address of the chosen head. `deq_o` never names more than one queue. Bit 0 of `deq_o` is the response queue, bit 1 the forwarded queue and bit 2 the upper queue.
- R2: With no valid head, `ev_valid_o`, `deq_o` and `err_o` are all zero, and `ev_o` is 0.
- R3: Response types are coded 0 DATA, 1 DATA_EXCLUSIVE, 2 ACK and 3 WB_ACK. Type 1 yields event 1 (exclusive data). Type 3 yields event 2 (writeback done). Either one dequeues the response.
- R4: A DATA response yields event 3 (data from a peer) when the line state is 8 or 11 (waiting for shared data) and `rsp_from_peer_i` is high.
- R5: Any other DATA response yields event 4 (final data) when pending count minus `rsp_acks_i` is zero modulo 2^CNT_W. Otherwise it yields event 5 (partial data).
- R6: An ACK response yields event 6 (final ack) when pending count minus `rsp_acks_i` is zero modulo 2^CNT_W. Otherwise it yields event 7 (partial ack).
- R7: The pending count is zero after reset. It is set to zero in the cycle after `txn_open_i`, and `txn_open_i` overrides a subtraction in the same cycle. Otherwise each dequeued DATA or ACK response subtracts its sign-extended `rsp_acks_i` from the count, and the change takes effect in the next cycle.
- R8: A known forwarded request (0 INV, 1 GETX, 2 UPGRADE, 3 GETS) yields event 8 (invalidate upper copy for a remote requester) without dequeue when `line_valid_i` is high and the line state is one of 2, 4, 6, 14, 15, 16 or 18 (held above).
- R9: Otherwise a forwarded request is dequeued as event 9 (INV), event 10 (GETX or UPGRADE) or event 11 (GETS).
- R10: Upper request types are coded 0 GETS, 1 GETX, 2 UPGRADE, 3 PUTX, 4 INV_DATA and 5 INV_ACK. Types 4 and 5 always yield events 12 and 13. Types 0 to 3 yield event 14 (load), 15 (store, for GETX and UPGRADE) or 16 (writeback) when the line is valid or a way is free. Each of these dequeues the request.
- R11: An upper request of type 0 to 3 that misses with no free way targets `victim_addr_i`, without dequeue. It yields event 17 when the victim state is held above (the R8 set) and event 18 (replacement) otherwise.
- R12: The following are unknown and raise `err_o` with no event: response types 4 to 7, forwarded types 4 to 7 and upper types 6 and 7. The offending head is dequeued to drop it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rsp_valid_i | input | 1 | Response queue head valid |
| rsp_type_i | input | 3 | Response type |
| rsp_from_peer_i | input | 1 | Response sent by a peer private cache |
| rsp_acks_i | input | ACK_W | Signed ack count carried by the response |
| rsp_addr_i | input | ADDR_W | Response line address |
| fwd_valid_i | input | 1 | Forwarded queue head valid |
| fwd_type_i | input | 3 | Forwarded request type |
| fwd_addr_i | input | ADDR_W | Forwarded line address |
| upq_valid_i | input | 1 | Upper queue head valid |
| upq_type_i | input | 3 | Upper request type |
| upq_addr_i | input | ADDR_W | Upper request line address |
| txn_open_i | input | 1 | A new transaction opens; clears the pending count |
| line_state_i | input | 5 | State of the line at `look_addr_o` |
| line_valid_i | input | 1 | Line at `look_addr_o` is allocated |
| way_free_i | input | 1 | A free way exists for `look_addr_o` |
| victim_addr_i | input | ADDR_W | Victim address for `look_addr_o` |
| victim_state_i | input | 5 | Victim line state |
| look_addr_o | output | ADDR_W | Address of the chosen head (0 when idle) |
| ev_valid_o | output | 1 | An event is present |
| ev_o | output | 5 | Event code |
| ev_addr_o | output | ADDR_W | Address the event applies to |
| deq_o | output | 3 | One-hot dequeue strobe |
| err_o | output | 1 | Unknown message type at the chosen head |

## Verification
The hardest condition to reach from the ports is a final data or final ack decode after a non-zero count. The count must first be moved away from zero by earlier consumed responses that carry mixed-sign ack counts. It must then be brought back exactly to the incoming count, and no `txn_open_i` may fall in between. The bench runs a directed open, partial data, partial ack and final ack chain. Long random runs then follow, with ack counts biased toward small values and sparse transaction opens. A behavioural model tracks the count as a plain integer and compares every output on every cycle.

// File: rtl/cohdec_pkg.sv
package cohdec_pkg;
  localparam int ST_W = 5;
  localparam int TY_W = 3;
  localparam int EV_W = 5;
  localparam int NQ   = 3;
  localparam int Q_RSP = 0;
  localparam int Q_FWD = 1;
  localparam int Q_UPQ = 2;

  typedef enum logic [ST_W-1:0] {
    ST_NP = 5'd0, ST_I = 5'd1, ST_S = 5'd2, ST_SS = 5'd3, ST_E = 5'd4,
    ST_EE = 5'd5, ST_M = 5'd6, ST_MM = 5'd7, ST_WS = 5'd8, ST_WM = 5'd9,
    ST_UPG = 5'd10, ST_WS_INV = 5'd11, ST_EVICT = 5'd12, ST_SINK = 5'd13,
    ST_S_UPX = 5'd14, ST_E_UPX = 5'd15, ST_M_UPX = 5'd16, ST_MM_UPX = 5'd17,
    ST_UPG_UPX = 5'd18
  } line_st_e;

  typedef enum logic [EV_W-1:0] {
    EV_NONE = 5'd0, EV_DATA_EXCL = 5'd1, EV_WB_DONE = 5'd2, EV_DATA_PEER = 5'd3,
    EV_DATA_LAST = 5'd4, EV_DATA_PART = 5'd5, EV_ACK_LAST = 5'd6,
    EV_ACK_PART = 5'd7, EV_UP_INV_REMOTE = 5'd8, EV_SNOOP_INV = 5'd9,
    EV_SNOOP_EXCL = 5'd10, EV_SNOOP_SHARED = 5'd11, EV_UP_DATA_ACK = 5'd12,
    EV_UP_ACK = 5'd13, EV_LOAD = 5'd14, EV_STORE = 5'd15, EV_WRITEBACK = 5'd16,
    EV_UP_INV_OWN = 5'd17, EV_REPLACE = 5'd18
  } ev_e;

  typedef enum logic [TY_W-1:0] {
    RT_DATA = 3'd0, RT_DATA_EXCL = 3'd1, RT_ACK = 3'd2, RT_WB_ACK = 3'd3
  } rsp_ty_e;

  typedef enum logic [TY_W-1:0] {
    FT_INV = 3'd0, FT_GETX = 3'd1, FT_UPGRADE = 3'd2, FT_GETS = 3'd3
  } fwd_ty_e;

  typedef enum logic [TY_W-1:0] {
    UT_GETS = 3'd0, UT_GETX = 3'd1, UT_UPGRADE = 3'd2, UT_PUTX = 3'd3,
    UT_INV_DATA = 3'd4, UT_INV_ACK = 3'd5
  } upq_ty_e;

  // line has a copy in the cache above
  function automatic logic held_above(input logic [ST_W-1:0] s);
    return (s == ST_S) || (s == ST_E) || (s == ST_M) || (s == ST_S_UPX) ||
           (s == ST_E_UPX) || (s == ST_M_UPX) || (s == ST_UPG_UPX);
  endfunction
endpackage

// File: rtl/cohdec_arb.sv
module cohdec_arb #(
  parameter int NQ     = 3,
  parameter int ADDR_W = 32
) (
  input  logic [NQ-1:0]             valid_i,
  input  logic [NQ-1:0][ADDR_W-1:0] addr_i,
  output logic [NQ-1:0]             grant_o,
  output logic [ADDR_W-1:0]         addr_o
);
  // lowest index wins
  always_comb begin
    grant_o = '0;
    addr_o  = '0;
    for (int q = NQ - 1; q >= 0; q--) begin
      if (valid_i[q]) begin
        grant_o    = '0;
        grant_o[q] = 1'b1;
        addr_o     = addr_i[q];
      end
    end
  end
endmodule

// File: rtl/cohdec_ackcnt.sv
module cohdec_ackcnt #(
  parameter int ACK_W = 4,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             sub_i,
  input  logic [ACK_W-1:0] acks_i,
  output logic [CNT_W-1:0] pend_o,
  output logic             last_o
);
  localparam int EXT_W = CNT_W - ACK_W;

  logic [CNT_W-1:0] pend_q, acks_ext, diff;

  assign acks_ext = {{EXT_W{acks_i[ACK_W-1]}}, acks_i};
  assign diff     = pend_q - acks_ext;
  assign last_o   = (diff == '0);
  assign pend_o   = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= '0;
    else if (open_i) pend_q <= '0;
    else if (sub_i)  pend_q <= diff;
  end

  p_open_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_i |=> (pend_o == '0));
  p_idle_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_i && !sub_i) |=> $stable(pend_o));
endmodule

// File: rtl/cohdec_rsp.sv
module cohdec_rsp
  import cohdec_pkg::*;
(
  input  logic [TY_W-1:0] type_i,
  input  logic            from_peer_i,
  input  logic [ST_W-1:0] state_i,
  input  logic            last_i,
  output logic [EV_W-1:0] ev_o,
  output logic            err_o,
  output logic            counts_o
);
  logic wait_shared;
  assign wait_shared = (state_i == ST_WS) || (state_i == ST_WS_INV);

  always_comb begin
    ev_o     = EV_NONE;
    err_o    = 1'b0;
    counts_o = 1'b0;
    unique case (type_i)
      RT_DATA_EXCL: ev_o = EV_DATA_EXCL;
      RT_WB_ACK:    ev_o = EV_WB_DONE;
      RT_DATA: begin
        counts_o = 1'b1;
        if (wait_shared && from_peer_i) ev_o = EV_DATA_PEER;
        else if (last_i)                ev_o = EV_DATA_LAST;
        else                            ev_o = EV_DATA_PART;
      end
      RT_ACK: begin
        counts_o = 1'b1;
        ev_o     = last_i ? EV_ACK_LAST : EV_ACK_PART;
      end
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/cohdec_fwd.sv
module cohdec_fwd
  import cohdec_pkg::*;
(
  input  logic [TY_W-1:0] type_i,
  input  logic            line_valid_i,
  input  logic [ST_W-1:0] state_i,
  output logic [EV_W-1:0] ev_o,
  output logic            err_o,
  output logic            hold_o
);
  logic above;
  assign above = line_valid_i && held_above(state_i);

  always_comb begin
    ev_o   = EV_NONE;
    err_o  = 1'b0;
    hold_o = 1'b0;
    if (type_i > FT_GETS) begin
      err_o = 1'b1;
    end else if (above) begin
      ev_o   = EV_UP_INV_REMOTE;
      hold_o = 1'b1;
    end else begin
      unique case (type_i)
        FT_INV:  ev_o = EV_SNOOP_INV;
        FT_GETS: ev_o = EV_SNOOP_SHARED;
        default: ev_o = EV_SNOOP_EXCL;
      endcase
    end
  end
endmodule

// File: rtl/cohdec_upq.sv
module cohdec_upq
  import cohdec_pkg::*;
(
  input  logic [TY_W-1:0] type_i,
  input  logic            line_valid_i,
  input  logic            way_free_i,
  input  logic [ST_W-1:0] victim_state_i,
  output logic [EV_W-1:0] ev_o,
  output logic            err_o,
  output logic            victim_o
);
  logic room;
  assign room = line_valid_i || way_free_i;

  always_comb begin
    ev_o     = EV_NONE;
    err_o    = 1'b0;
    victim_o = 1'b0;
    unique case (type_i)
      UT_INV_DATA: ev_o = EV_UP_DATA_ACK;
      UT_INV_ACK:  ev_o = EV_UP_ACK;
      UT_GETS, UT_GETX, UT_UPGRADE, UT_PUTX: begin
        if (!room) begin
          victim_o = 1'b1;
          ev_o     = held_above(victim_state_i) ? EV_UP_INV_OWN : EV_REPLACE;
        end else if (type_i == UT_GETS) ev_o = EV_LOAD;
        else if (type_i == UT_PUTX)     ev_o = EV_WRITEBACK;
        else                            ev_o = EV_STORE;
      end
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/coh_event_decoder.sv
module coh_event_decoder
  import cohdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ACK_W  = 4,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rsp_valid_i,
  input  logic [2:0]        rsp_type_i,
  input  logic              rsp_from_peer_i,
  input  logic [ACK_W-1:0]  rsp_acks_i,
  input  logic [ADDR_W-1:0] rsp_addr_i,
  input  logic              fwd_valid_i,
  input  logic [2:0]        fwd_type_i,
  input  logic [ADDR_W-1:0] fwd_addr_i,
  input  logic              upq_valid_i,
  input  logic [2:0]        upq_type_i,
  input  logic [ADDR_W-1:0] upq_addr_i,
  input  logic              txn_open_i,
  input  logic [4:0]        line_state_i,
  input  logic              line_valid_i,
  input  logic              way_free_i,
  input  logic [ADDR_W-1:0] victim_addr_i,
  input  logic [4:0]        victim_state_i,
  output logic [ADDR_W-1:0] look_addr_o,
  output logic              ev_valid_o,
  output logic [4:0]        ev_o,
  output logic [ADDR_W-1:0] ev_addr_o,
  output logic [2:0]        deq_o,
  output logic              err_o
);
  logic [NQ-1:0]             q_valid, grant;
  logic [NQ-1:0][ADDR_W-1:0] q_addr;
  logic [ADDR_W-1:0]         sel_addr;
  logic [EV_W-1:0]           rsp_ev, fwd_ev, upq_ev, ev;
  logic                      rsp_err, fwd_err, upq_err, rsp_counts;
  logic                      fwd_hold, upq_victim, cnt_last;
  logic [CNT_W-1:0]          pend;
  logic                      err, use_victim;
  logic [NQ-1:0]             deq;

  assign q_valid = {upq_valid_i, fwd_valid_i, rsp_valid_i};
  assign q_addr  = {upq_addr_i, fwd_addr_i, rsp_addr_i};

  cohdec_arb #(.NQ(NQ), .ADDR_W(ADDR_W)) u_arb (
    .valid_i(q_valid), .addr_i(q_addr), .grant_o(grant), .addr_o(sel_addr)
  );

  cohdec_ackcnt #(.ACK_W(ACK_W), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .open_i(txn_open_i),
    .sub_i(grant[Q_RSP] && rsp_counts),
    .acks_i(rsp_acks_i), .pend_o(pend), .last_o(cnt_last)
  );

  cohdec_rsp u_rsp (
    .type_i(rsp_type_i), .from_peer_i(rsp_from_peer_i), .state_i(line_state_i),
    .last_i(cnt_last), .ev_o(rsp_ev), .err_o(rsp_err), .counts_o(rsp_counts)
  );

  cohdec_fwd u_fwd (
    .type_i(fwd_type_i), .line_valid_i, .state_i(line_state_i),
    .ev_o(fwd_ev), .err_o(fwd_err), .hold_o(fwd_hold)
  );

  cohdec_upq u_upq (
    .type_i(upq_type_i), .line_valid_i, .way_free_i, .victim_state_i,
    .ev_o(upq_ev), .err_o(upq_err), .victim_o(upq_victim)
  );

  always_comb begin
    ev         = EV_NONE;
    err        = 1'b0;
    use_victim = 1'b0;
    deq        = '0;
    if (grant[Q_RSP]) begin
      ev         = rsp_ev;
      err        = rsp_err;
      deq[Q_RSP] = 1'b1;
    end else if (grant[Q_FWD]) begin
      ev         = fwd_ev;
      err        = fwd_err;
      deq[Q_FWD] = !fwd_hold;
    end else if (grant[Q_UPQ]) begin
      ev         = upq_ev;
      err        = upq_err;
      use_victim = upq_victim;
      deq[Q_UPQ] = !upq_victim;
    end
  end

  assign look_addr_o = sel_addr;
  assign ev_o        = ev;
  assign ev_valid_o  = (ev != EV_NONE);
  assign ev_addr_o   = use_victim ? victim_addr_i : sel_addr;
  assign deq_o       = deq;
  assign err_o       = err;

  p_deq_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(deq_o));
  p_rsp_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |-> (deq_o[2:1] == 2'b00));
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_i || fwd_valid_i || upq_valid_i) |-> (!ev_valid_o && deq_o == '0 && !err_o));
  p_remote_inv_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_o == EV_UP_INV_REMOTE) |-> (deq_o == '0));
  p_victim_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_o == EV_UP_INV_OWN || ev_o == EV_REPLACE) |-> (deq_o == '0 && ev_addr_o == victim_addr_i));
  p_err_silent_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!ev_valid_o && $countones(deq_o) == 1));
  p_count_zero_after_open_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_open_i |=> (pend == '0));
endmodule

// File: tb/sim_coh_event_decoder.sv
`timescale 1ns/1ps
module sim_coh_event_decoder;
  localparam int ADDR_W = 32;
  localparam int ACK_W  = 4;
  localparam int CNT_W  = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic              rsp_valid, rsp_peer, fwd_valid, upq_valid, txn_open, lv, wf;
  logic [2:0]        rsp_type, fwd_type, upq_type;
  logic [ACK_W-1:0]  rsp_acks;
  logic [ADDR_W-1:0] rsp_addr, fwd_addr, upq_addr, vic_addr;
  logic [4:0]        lstate, vstate;
  logic [ADDR_W-1:0] look_addr, ev_addr;
  logic              ev_valid, err;
  logic [4:0]        ev;
  logic [2:0]        deq;

  coh_event_decoder #(.ADDR_W(ADDR_W), .ACK_W(ACK_W), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .rsp_valid_i(rsp_valid), .rsp_type_i(rsp_type), .rsp_from_peer_i(rsp_peer),
    .rsp_acks_i(rsp_acks), .rsp_addr_i(rsp_addr),
    .fwd_valid_i(fwd_valid), .fwd_type_i(fwd_type), .fwd_addr_i(fwd_addr),
    .upq_valid_i(upq_valid), .upq_type_i(upq_type), .upq_addr_i(upq_addr),
    .txn_open_i(txn_open), .line_state_i(lstate), .line_valid_i(lv),
    .way_free_i(wf), .victim_addr_i(vic_addr), .victim_state_i(vstate),
    .look_addr_o(look_addr), .ev_valid_o(ev_valid), .ev_o(ev),
    .ev_addr_o(ev_addr), .deq_o(deq), .err_o(err)
  );

  int checks = 0;
  int errors = 0;
  int pend   = 0;
  bit done   = 0;

  function automatic bit upheld(input logic [4:0] s);
    return s == 2 || s == 4 || s == 6 || s == 14 || s == 15 || s == 16 || s == 18;
  endfunction

  function automatic bit last_hit(input int p, input logic [ACK_W-1:0] a);
    int d = p - int'($signed(a));
    return (d & ((1 << CNT_W) - 1)) == 0;
  endfunction

  task automatic idle();
    rsp_valid = 0; fwd_valid = 0; upq_valid = 0; txn_open = 0;
    rsp_type = 0; fwd_type = 0; upq_type = 0; rsp_peer = 0; rsp_acks = 0;
    rsp_addr = 0; fwd_addr = 0; upq_addr = 0; vic_addr = 0;
    lstate = 0; vstate = 0; lv = 0; wf = 0;
  endtask

  // compare just ahead of the rising edge, then advance the model
  task automatic tick();
    int e_ev = 0; int e_deq = 0; bit e_err = 0;
    logic [ADDR_W-1:0] e_la = '0, e_ea = '0;
    string tag = "R2";
    #1;
    if (rsp_valid) begin
      e_la = rsp_addr; e_ea = rsp_addr; e_deq = 1;
      case (rsp_type)
        3'd1: begin e_ev = 1; tag = "R3"; end
        3'd3: begin e_ev = 2; tag = "R3"; end
        3'd0: begin
          if ((lstate == 8 || lstate == 11) && rsp_peer) begin e_ev = 3; tag = "R4"; end
          else begin e_ev = last_hit(pend, rsp_acks) ? 4 : 5; tag = "R5 R7"; end
        end
        3'd2: begin e_ev = last_hit(pend, rsp_acks) ? 6 : 7; tag = "R6 R7"; end
        default: begin e_err = 1; tag = "R12"; end
      endcase
    end else if (fwd_valid) begin
      e_la = fwd_addr; e_ea = fwd_addr;
      if (fwd_type > 3) begin e_err = 1; e_deq = 2; tag = "R12"; end
      else if (lv && upheld(lstate)) begin e_ev = 8; tag = "R8"; end
      else begin
        e_deq = 2; tag = "R9";
        e_ev = (fwd_type == 0) ? 9 : (fwd_type == 3) ? 11 : 10;
      end
    end else if (upq_valid) begin
      e_la = upq_addr; e_ea = upq_addr;
      if (upq_type == 4) begin e_ev = 12; e_deq = 4; tag = "R10"; end
      else if (upq_type == 5) begin e_ev = 13; e_deq = 4; tag = "R10"; end
      else if (upq_type > 5) begin e_err = 1; e_deq = 4; tag = "R12"; end
      else if (lv || wf) begin
        e_deq = 4; tag = "R10";
        e_ev = (upq_type == 0) ? 14 : (upq_type == 3) ? 16 : 15;
      end else begin
        e_ea = vic_addr; tag = "R11";
        e_ev = upheld(vstate) ? 17 : 18;
      end
    end
    if (int'(rsp_valid) + int'(fwd_valid) + int'(upq_valid) > 1) tag = {tag, " R1"};
    checks++;
    if (int'(ev) != e_ev || ev_valid != (e_ev != 0) || int'(deq) != e_deq ||
        err != e_err || look_addr != e_la || (e_ev != 0 && ev_addr != e_ea)) begin
      errors++;
      $display("FAIL %s: ev=%0d deq=%0d err=%0d la=%h ea=%h expected ev=%0d deq=%0d err=%0d la=%h ea=%h",
               tag, ev, deq, err, look_addr, ev_addr, e_ev, e_deq, e_err, e_la, e_ea);
    end
    @(posedge clk);
    if (txn_open) pend = 0;
    else if (e_deq == 1 && (rsp_type == 0 || rsp_type == 2)) pend -= int'($signed(rsp_acks));
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    tick();                                    // R2 reset/idle
    rsp_valid = 1; rsp_type = 2; rsp_acks = 0; rsp_addr = 32'h100;
    tick();                                    // R6 R7: count zero after reset
    idle(); txn_open = 1; tick();              // R7 open
    idle(); rsp_valid = 1; rsp_type = 0; rsp_acks = 4'hE; lstate = 9; rsp_addr = 32'h200;
    tick();                                    // R5 partial, count -> 2
    rsp_type = 2; rsp_acks = 1; tick();        // R6 partial, count -> 1
    rsp_acks = 1; tick();                      // R6 final
    rsp_type = 0; lstate = 8; rsp_peer = 1; tick();      // R4
    rsp_type = 1; tick(); rsp_type = 3; tick();          // R3
    rsp_type = 5; tick();                                 // R12
    idle(); fwd_valid = 1; fwd_addr = 32'h300; lv = 1; lstate = 14;
    fwd_type = 1; tick();                                 // R8
    lstate = 5; fwd_type = 0; tick(); fwd_type = 2; tick(); fwd_type = 3; tick(); // R9
    fwd_type = 6; tick();                                 // R12
    idle(); upq_valid = 1; upq_addr = 32'h400; vic_addr = 32'h480;
    upq_type = 4; tick(); upq_type = 5; tick();           // R10
    wf = 1; upq_type = 0; tick(); upq_type = 3; tick();   // R10
    wf = 0; lv = 0; vstate = 6; upq_type = 1; tick();     // R11 own invalidate
    vstate = 7; tick();                                   // R11 replace
    upq_type = 7; tick();                                 // R12
    fwd_valid = 1; fwd_type = 0; rsp_valid = 1; rsp_type = 3; tick(); // R1
    rsp_valid = 0; tick();                                // R1
    for (int n = 0; n < 6000; n++) begin
      rsp_valid = ($urandom % 4) == 0;
      fwd_valid = ($urandom % 3) == 0;
      upq_valid = ($urandom % 2) == 0;
      txn_open  = ($urandom % 8) == 0;
      rsp_type  = 3'($urandom % 8);
      fwd_type  = 3'($urandom % 8);
      upq_type  = 3'($urandom % 8);
      rsp_peer  = 1'($urandom);
      rsp_acks  = ($urandom % 2) ? 4'($urandom) : 4'(int'($urandom % 4) - 2);
      rsp_addr  = $urandom; fwd_addr = $urandom; upq_addr = $urandom; vic_addr = $urandom;
      lstate    = 5'($urandom % 19);
      vstate    = 5'($urandom % 19);
      lv        = 1'($urandom); wf = 1'($urandom);
      tick();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule